// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block keeps wall-clock time and calendar date as a chain of packed-BCD counters: seconds, minutes, hours in 24-hour form, a day-of-week count, day of month, month and a two-digit year. A one-cycle enable, normally pulsed once per second by a divider elsewhere on the chip, advances the chain by one second. A run input gates the count, so software can freeze the time without losing it.

A parallel load writes every field at once, for setting the clock. The day-of-month rollover follows the current month's length, with February extended to 29 days in years whose value is a multiple of four. Year 00 counts as a leap year, which is correct through the year 2099 when the century is 2000. All outputs come straight from registers, and every change appears on the clock edge that samples the enable or the load.

Top module: `bcd_calendar_counter`

## Requirements
- R1: While reset is asserted, and after it, until a load or an advance, the outputs read seconds 8'h00, minutes 8'h00, hours 8'h00, day-of-week 8'h01, date 8'h01, month 8'h01 and year 8'h00.
- R2: Each advance adds one to the seconds. Seconds and minutes count 00 to 59 in packed BCD (tens in bits 7:4, units in bits 3:0). When the seconds pass 59 they go to 00 and the minutes advance. When the minutes pass 59 they go to 00 and the hours advance.
- R3: Hours count 00 to 23. From 23 they go to 00 and one day is added.
- R4: Day-of-week counts 01 to 07 and goes from 07 back to 01 on every added day.
- R5: The date goes back to 01 and the month advances when the date passes 30 in months 04, 06, 09 and 11, and when it passes 31 in months 01, 03, 05, 07, 08, 10 and 12.
- R6: In month 02 the date passes 29 when the year value is divisible by 4, year 00 included, and it passes 28 in any other year.
- R7: Months count 01 to 12. Going from 12 to 01 advances the year, and year 99 goes to 00 with no further effect.
- R8: When load_i is high at a clock edge, every field takes its load input on that edge. This holds whatever run_i is, and a tick in the same cycle is discarded.
- R9: When run_i is low and load_i is low, every field holds its value and tick_i has no effect.
- R10: Each clock edge with tick_i and run_i high and load_i low advances the time by exactly one second. Ticks on consecutive cycles each count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-second advance enable |
| run_i | input | 1 | Counting enabled when high |
| load_i | input | 1 | Parallel load of all fields |
| ld_sec_i | input | 8 | Seconds to load, BCD |
| ld_min_i | input | 8 | Minutes to load, BCD |
| ld_hour_i | input | 8 | Hours to load, BCD |
| ld_dow_i | input | 8 | Day-of-week to load, BCD 01-07 |
| ld_date_i | input | 8 | Date to load, BCD |
| ld_month_i | input | 8 | Month to load, BCD |
| ld_year_i | input | 8 | Year to load, BCD |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hours |
| dow_o | output | 8 | Day-of-week |
| date_o | output | 8 | Date |
| month_o | output | 8 | Month |
| year_o | output | 8 | Year |

## Verification
A load or an advance is visible on the outputs one cycle after its inputs are presented, at the edge that samples them, and this is true of every field. A full carry from seconds to year also settles in that same edge, because the whole cascade is combinational. The bench changes inputs just after a rising edge and samples outputs on the falling edge, so each result is read exactly one edge after its cause. A behavioural integer model runs on the same edges and is compared on every falling edge, and directed checks read the fields at the month, leap-year and year boundaries after the last edge of each stimulus.

// File: rtl/cal_pkg.sv
package cal_pkg;
    localparam int DIGITS = 2;
    localparam int FW     = 4 * DIGITS;
    localparam int NF     = 7;

    typedef logic [FW-1:0] bcd_t;

    typedef struct packed {
        bcd_t sec;
        bcd_t min;
        bcd_t hour;
        bcd_t dow;
        bcd_t date;
        bcd_t month;
        bcd_t year;
    } cal_t;

    localparam int F_SEC   = 0;
    localparam int F_MIN   = 1;
    localparam int F_HOUR  = 2;
    localparam int F_DOW   = 3;
    localparam int F_DATE  = 4;
    localparam int F_MONTH = 5;
    localparam int F_YEAR  = 6;

    localparam bcd_t SEC_TOP   = 8'h59;
    localparam bcd_t MIN_TOP   = 8'h59;
    localparam bcd_t HOUR_TOP  = 8'h23;
    localparam bcd_t DOW_TOP   = 8'h07;
    localparam bcd_t MONTH_TOP = 8'h12;
    localparam bcd_t YEAR_TOP  = 8'h99;
    localparam bcd_t ZERO_BCD  = 8'h00;
    localparam bcd_t ONE_BCD   = 8'h01;

    localparam cal_t CAL_RESET = '{sec: 8'h00, min: 8'h00, hour: 8'h00,
                                   dow: 8'h01, date: 8'h01, month: 8'h01,
                                   year: 8'h00};
endpackage

// File: rtl/bcd_step.sv
module bcd_step #(
    parameter int DIGITS = 2,
    localparam int W = 4 * DIGITS
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] first,
    input  logic [W-1:0] last,
    input  logic         en,
    output logic [W-1:0] nxt,
    output logic         at_last
);
    logic [W-1:0] inc_d;

    always_comb begin
        logic carry;
        inc_d = cur;
        carry = 1'b1;
        for (int d = 0; d < DIGITS; d++) begin
            if (carry) begin
                if (inc_d[4*d +: 4] >= 4'd9) begin
                    inc_d[4*d +: 4] = 4'd0;
                end else begin
                    inc_d[4*d +: 4] = inc_d[4*d +: 4] + 4'd1;
                    carry = 1'b0;
                end
            end
        end
    end

    // Values above the top are folded back as well, so a bad load recovers.
    assign at_last = (cur >= last);

    always_comb begin
        if (!en)          nxt = cur;
        else if (at_last) nxt = first;
        else              nxt = inc_d;
    end
endmodule

// File: rtl/cal_month_last.sv
module cal_month_last
    import cal_pkg::*;
(
    input  bcd_t month,
    input  bcd_t year,
    output bcd_t last_day,
    output logic leap
);
    // A two-digit BCD value is a multiple of 4 when an even tens digit pairs
    // with units 0/4/8 or an odd tens digit pairs with units 2/6.
    always_comb begin
        if (year[4]) leap = (year[3:0] == 4'd2) || (year[3:0] == 4'd6);
        else         leap = (year[3:0] == 4'd0) || (year[3:0] == 4'd4) ||
                            (year[3:0] == 4'd8);
    end

    always_comb begin
        case (month)
            8'h02:                      last_day = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
            default:                    last_day = 8'h31;
        endcase
    end
endmodule

// File: rtl/bcd_calendar_counter.sv
module bcd_calendar_counter
    import cal_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_i,
    input  logic        run_i,
    input  logic        load_i,
    input  logic [7:0]  ld_sec_i,
    input  logic [7:0]  ld_min_i,
    input  logic [7:0]  ld_hour_i,
    input  logic [7:0]  ld_dow_i,
    input  logic [7:0]  ld_date_i,
    input  logic [7:0]  ld_month_i,
    input  logic [7:0]  ld_year_i,
    output logic [7:0]  sec_o,
    output logic [7:0]  min_o,
    output logic [7:0]  hour_o,
    output logic [7:0]  dow_o,
    output logic [7:0]  date_o,
    output logic [7:0]  month_o,
    output logic [7:0]  year_o
);
    cal_t cal_q, cal_d;

    bcd_t cur_f   [NF];
    bcd_t first_f [NF];
    bcd_t last_f  [NF];
    bcd_t nxt_f   [NF];
    logic en_f    [NF];
    logic top_f   [NF];

    bcd_t month_last;
    logic leap_yr;

    cal_month_last u_mlen (
        .month    (cal_q.month),
        .year     (cal_q.year),
        .last_day (month_last),
        .leap     (leap_yr)
    );

    always_comb begin
        cur_f[F_SEC]   = cal_q.sec;
        cur_f[F_MIN]   = cal_q.min;
        cur_f[F_HOUR]  = cal_q.hour;
        cur_f[F_DOW]   = cal_q.dow;
        cur_f[F_DATE]  = cal_q.date;
        cur_f[F_MONTH] = cal_q.month;
        cur_f[F_YEAR]  = cal_q.year;

        first_f[F_SEC]   = ZERO_BCD;
        first_f[F_MIN]   = ZERO_BCD;
        first_f[F_HOUR]  = ZERO_BCD;
        first_f[F_DOW]   = ONE_BCD;
        first_f[F_DATE]  = ONE_BCD;
        first_f[F_MONTH] = ONE_BCD;
        first_f[F_YEAR]  = ZERO_BCD;

        last_f[F_SEC]   = SEC_TOP;
        last_f[F_MIN]   = MIN_TOP;
        last_f[F_HOUR]  = HOUR_TOP;
        last_f[F_DOW]   = DOW_TOP;
        last_f[F_DATE]  = month_last;
        last_f[F_MONTH] = MONTH_TOP;
        last_f[F_YEAR]  = YEAR_TOP;
    end

    // Carry cascade: day carry feeds both day-of-week and date.
    always_comb begin
        en_f[F_SEC]   = tick_i && run_i && !load_i;
        en_f[F_MIN]   = en_f[F_SEC]   && top_f[F_SEC];
        en_f[F_HOUR]  = en_f[F_MIN]   && top_f[F_MIN];
        en_f[F_DOW]   = en_f[F_HOUR]  && top_f[F_HOUR];
        en_f[F_DATE]  = en_f[F_HOUR]  && top_f[F_HOUR];
        en_f[F_MONTH] = en_f[F_DATE]  && top_f[F_DATE];
        en_f[F_YEAR]  = en_f[F_MONTH] && top_f[F_MONTH];
    end

    for (genvar i = 0; i < NF; i++) begin : g_field
        bcd_step #(.DIGITS(DIGITS)) u_step (
            .cur     (cur_f[i]),
            .first   (first_f[i]),
            .last    (last_f[i]),
            .en      (en_f[i]),
            .nxt     (nxt_f[i]),
            .at_last (top_f[i])
        );
    end

    always_comb begin
        if (load_i) begin
            cal_d.sec   = ld_sec_i;
            cal_d.min   = ld_min_i;
            cal_d.hour  = ld_hour_i;
            cal_d.dow   = ld_dow_i;
            cal_d.date  = ld_date_i;
            cal_d.month = ld_month_i;
            cal_d.year  = ld_year_i;
        end else begin
            cal_d.sec   = nxt_f[F_SEC];
            cal_d.min   = nxt_f[F_MIN];
            cal_d.hour  = nxt_f[F_HOUR];
            cal_d.dow   = nxt_f[F_DOW];
            cal_d.date  = nxt_f[F_DATE];
            cal_d.month = nxt_f[F_MONTH];
            cal_d.year  = nxt_f[F_YEAR];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cal_q <= CAL_RESET;
        else        cal_q <= cal_d;
    end

    assign sec_o   = cal_q.sec;
    assign min_o   = cal_q.min;
    assign hour_o  = cal_q.hour;
    assign dow_o   = cal_q.dow;
    assign date_o  = cal_q.date;
    assign month_o = cal_q.month;
    assign year_o  = cal_q.year;

    // Assertions assume the load inputs carry in-range values.
    assert_sec_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_q.sec[3:0] <= 4'd9) && (cal_q.sec <= 8'h59));

    assert_hour_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_q.hour[3:0] <= 4'd9) && (cal_q.hour <= 8'h23));

    assert_dow_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_q.dow >= 8'h01) && (cal_q.dow <= 8'h07));

    assert_date_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_q.date >= 8'h01) && (cal_q.date <= month_last));

    assert_feb_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_q.month == 8'h02) |-> (month_last == 8'h28 || month_last == 8'h29));

    assert_year_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_f[F_YEAR] && cal_q.year == 8'h99) |=> (cal_q.year == 8'h00));

    assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cal_q.sec == $past(ld_sec_i) && cal_q.hour == $past(ld_hour_i) &&
                    cal_q.date == $past(ld_date_i) && cal_q.year == $past(ld_year_i)));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !load_i) |=> $stable(cal_q));

    assert_one_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (en_f[F_SEC] && cal_q.sec[3:0] != 4'd9) |=> (cal_q.sec[3:0] == $past(cal_q.sec[3:0]) + 4'd1));
endmodule

// File: tb/bcd_calendar_counter_test.sv
module bcd_calendar_counter_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, run = 1'b0, load = 1'b0;
    logic [7:0] l_sec = 0, l_min = 0, l_hour = 0, l_dow = 8'h01,
                l_date = 8'h01, l_mon = 8'h01, l_year = 0;
    logic [7:0] sec, mn, hour, dow, date, mon, year;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    string cur_req = "R1";

    // reference state as plain integers
    int m_sec, m_min, m_hr, m_dow, m_date, m_mon, m_yr;

    always #5 clk = ~clk;

    bcd_calendar_counter uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .run_i(run), .load_i(load),
        .ld_sec_i(l_sec), .ld_min_i(l_min), .ld_hour_i(l_hour), .ld_dow_i(l_dow),
        .ld_date_i(l_date), .ld_month_i(l_mon), .ld_year_i(l_year),
        .sec_o(sec), .min_o(mn), .hour_o(hour), .dow_o(dow), .date_o(date),
        .month_o(mon), .year_o(year)
    );

    function automatic logic [7:0] to_bcd(int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic int from_bcd(logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic int days_in(int mo, int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [55:0] pack7(int s, int m, int h, int dw, int dt, int mo, int y);
        return {to_bcd(s), to_bcd(m), to_bcd(h), to_bcd(dw), to_bcd(dt), to_bcd(mo), to_bcd(y)};
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_sec = 0; m_min = 0; m_hr = 0; m_dow = 1; m_date = 1; m_mon = 1; m_yr = 0;
        end else if (load) begin
            m_sec = from_bcd(l_sec); m_min = from_bcd(l_min); m_hr = from_bcd(l_hour);
            m_dow = from_bcd(l_dow); m_date = from_bcd(l_date); m_mon = from_bcd(l_mon);
            m_yr = from_bcd(l_year);
        end else if (run && tick) begin
            m_sec++;
            if (m_sec == 60) begin
                m_sec = 0; m_min++;
                if (m_min == 60) begin
                    m_min = 0; m_hr++;
                    if (m_hr == 24) begin
                        m_hr = 0;
                        m_dow = (m_dow % 7) + 1;
                        m_date++;
                        if (m_date > days_in(m_mon, m_yr)) begin
                            m_date = 1; m_mon++;
                            if (m_mon == 13) begin
                                m_mon = 1;
                                m_yr = (m_yr + 1) % 100;
                            end
                        end
                    end
                end
            end
        end
    end

    task automatic check(string req, logic [55:0] act, logic [55:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [55:0] outs();
        return {sec, mn, hour, dow, date, mon, year};
    endfunction

    // per-cycle comparison against the model, away from the rising edge
    always @(negedge clk) begin
        if (!done)
            check(rst_n ? cur_req : "R1", outs(),
                  pack7(m_sec, m_min, m_hr, m_dow, m_date, m_mon, m_yr));
    end

    task automatic do_ticks(int n);
        @(posedge clk); #1 tick = 1'b1;
        repeat (n) @(posedge clk);
        #1 tick = 1'b0;
    endtask

    task automatic do_load(int s, int m, int h, int dw, int dt, int mo, int y);
        @(posedge clk); #1;
        load = 1'b1;
        l_sec = to_bcd(s); l_min = to_bcd(m); l_hour = to_bcd(h); l_dow = to_bcd(dw);
        l_date = to_bcd(dt); l_mon = to_bcd(mo); l_year = to_bcd(y);
        @(posedge clk); #1 load = 1'b0;
    endtask

    task automatic feb_case(int y, int exp_date, int exp_mon);
        do_load(59, 59, 23, 2, 28, 2, y);
        do_ticks(1);
        @(negedge clk);
        check("R6", {48'h0, date, mon}, {48'h0, to_bcd(exp_date), to_bcd(exp_mon)});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", outs(), pack7(0, 0, 0, 1, 1, 1, 0));
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1", outs(), pack7(0, 0, 0, 1, 1, 1, 0));

        cur_req = "R2";
        run = 1'b1;
        do_ticks(75);
        @(negedge clk);
        check("R2", {40'h0, sec, mn}, {40'h0, 8'h15, 8'h01});
        do_ticks(3600);
        @(negedge clk);
        check("R2", {32'h0, sec, mn, hour}, {32'h0, 8'h15, 8'h01, 8'h01});

        cur_req = "R3";
        do_load(50, 59, 23, 7, 30, 4, 23);
        do_ticks(10);
        @(negedge clk);
        check("R3", {48'h0, hour, sec}, 56'h0);
        check("R4", {48'h0, dow}, 56'h01);
        check("R5", {40'h0, date, mon}, {40'h0, 8'h01, 8'h05});

        cur_req = "R5";
        do_load(59, 59, 23, 3, 31, 1, 23);
        do_ticks(1);
        @(negedge clk);
        check("R5", outs(), pack7(0, 0, 0, 4, 1, 2, 23));
        do_load(59, 59, 23, 3, 30, 5, 23);
        do_ticks(1);
        @(negedge clk);
        check("R5", {40'h0, date, mon}, {40'h0, 8'h31, 8'h05});
        do_load(59, 59, 23, 3, 30, 11, 23);
        do_ticks(1);
        @(negedge clk);
        check("R5", {40'h0, date, mon}, {40'h0, 8'h01, 8'h12});

        cur_req = "R6";
        feb_case(24, 29, 2);
        feb_case(23, 1, 3);
        feb_case(0, 29, 2);
        feb_case(10, 1, 3);
        feb_case(12, 29, 2);
        do_load(59, 59, 23, 2, 29, 2, 96);
        do_ticks(1);
        @(negedge clk);
        check("R6", {48'h0, date, mon}, {48'h0, 8'h01, 8'h03});

        cur_req = "R7";
        do_load(59, 59, 23, 6, 31, 12, 99);
        do_ticks(1);
        @(negedge clk);
        check("R7", outs(), pack7(0, 0, 0, 7, 1, 1, 0));
        do_load(59, 59, 23, 6, 31, 12, 41);
        do_ticks(1);
        @(negedge clk);
        check("R7", {48'h0, year}, 56'h42);

        cur_req = "R9";
        do_load(30, 12, 8, 2, 15, 6, 50);
        run = 1'b0;
        do_ticks(20);
        @(negedge clk);
        check("R9", outs(), pack7(30, 12, 8, 2, 15, 6, 50));

        cur_req = "R8";
        do_load(1, 2, 3, 4, 5, 7, 8);
        @(negedge clk);
        check("R8", outs(), pack7(1, 2, 3, 4, 5, 7, 8));
        run = 1'b1;
        @(posedge clk); #1;
        tick = 1'b1; load = 1'b1;
        l_sec = 8'h59; l_min = 8'h59; l_hour = 8'h23; l_dow = 8'h07;
        l_date = 8'h31; l_mon = 8'h12; l_year = 8'h99;
        @(posedge clk); #1 load = 1'b0; tick = 1'b0;
        @(negedge clk);
        check("R8", outs(), pack7(59, 59, 23, 7, 31, 12, 99));

        cur_req = "R10";
        do_load(0, 0, 0, 1, 1, 1, 0);
        for (int k = 0; k < 5; k++) begin
            do_ticks(1);
            repeat (3) @(posedge clk);
        end
        @(negedge clk);
        check("R10", {48'h0, sec}, 56'h05);
        do_load(0, 0, 0, 5, 28, 2, 99);
        do_ticks(90000);
        @(negedge clk);
        check("R10", outs(), pack7(0, 0, 1, 6, 1, 3, 99));

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule